// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a multi-function I/O controller. Software reaches it through two byte-wide ports on a small bus: an index port that names a register and a data port that reads or writes the named register. The register space stays sealed until a two-byte unlock key arrives on the index port. A single exit byte seals it again, so a stray access from an unrelated driver cannot reconfigure the peripherals.

While the port is open, a logical-device selector picks one of several per-device register banks. Each bank holds an enable flag, a 16-bit I/O base address and an interrupt number. All banks drive dedicated output pins that steer the peripherals, which are outside this block. A few global registers sit beside the banks: the device selector, a soft-reset trigger that clears every bank, and a byte that places and enables a general-purpose I/O window.

Reads are combinational: `rdata` reflects the addressed register in the same cycle that `rd_en` is high. Writes take effect at the next rising clock edge.

Top module: `cfgp_port`

## Requirements
- R1: The port opens (`cfg_open` = 1) only when two consecutive index-port writes carry 0x51 and then 0x23.
- R2: After an index write of 0x51, any index write other than 0x23 (0x51 included) puts the unlock detector back to idle, so a following 0x23 does not open the port.
- R3: While open, an index write of 0xBB closes the port at the next edge and is not stored as the index.
- R4: While closed, data-port writes change no register, index writes do not load the index, and reads of either port return 0xFF.
- R5: Index 0x07 holds the selected device number (0 to NUM_DEV-1), which reads back. A write of a value not below NUM_DEV leaves the selection unchanged.
- R6: Index 0x30 bit 0 of the selected bank drives `dev_active[n]`. It reads back as 0000000a.
- R7: Indices 0x60 and 0x61 of the selected bank hold the high and low bytes of `dev_base[n*16 +: 16]`.
- R8: Index 0x70 of the selected bank keeps the low IRQ_W bits of the written byte on `dev_irq[n*IRQ_W +: IRQ_W]` and reads back zero-extended.
- R9: A data write with bit 0 set to index 0x02 returns every bank to zero at the next edge. The device selection and index 0x03 keep their values, and index 0x02 reads as 0x00.
- R10: Index 0x03 stores a full byte that reads back. Bit 7 drives `gpio_win_en` and bits 1:0 drive `gpio_win_sel`.
- R11: While open, reading the data port at an index with no register returns 0x00. Reading the index port returns the stored index.
- R12: After hardware reset the port is closed, every bank is zero, the selection is device 0 and index 0x03 is 0x00.
- R13: `rdata` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| cfg_open | output | 1 | High while the register space is unlocked |
| dev_active | output | NUM_DEV | Per-device enable |
| dev_base | output | NUM_DEV*16 | Per-device I/O base address, device n at bits n*16 and up |
| dev_irq | output | NUM_DEV*IRQ_W | Per-device interrupt number |
| gpio_win_en | output | 1 | General-purpose I/O window enable |
| gpio_win_sel | output | 2 | General-purpose I/O window port-pair select |

## Verification
A detector stuck in its half-keyed state opens the port on a lone 0x23. A detector that misses the reset-to-idle rule accepts key bytes that are not adjacent. Either fault shows on `cfg_open` one edge after the offending index write, so the bench tries every possible second byte after 0x51. A bank decode error writes the wrong device, or misses a byte of the base address. That shows on the device output pins at the next edge and in the data-port readback once the selector is moved. A soft reset that also clears the global registers shows on the 0x03 readback and the window pins at once.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam logic [7:0] IDX_SRST = 8'h02;
   localparam logic [7:0] IDX_GSEL = 8'h03;
   localparam logic [7:0] IDX_LDN  = 8'h07;
   localparam logic [7:0] IDX_ACT  = 8'h30;
   localparam logic [7:0] IDX_BHI  = 8'h60;
   localparam logic [7:0] IDX_BLO  = 8'h61;
   localparam logic [7:0] IDX_IRQ  = 8'h70;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_t;

   function automatic logic is_bank_idx(input logic [7:0] idx);
      return (idx == IDX_ACT) || (idx == IDX_BHI) || (idx == IDX_BLO) || (idx == IDX_IRQ);
   endfunction
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
   import cfgp_pkg::*;
#(
   parameter logic [7:0] KEY_A  = 8'h51,
   parameter logic [7:0] KEY_B  = 8'h23,
   parameter logic [7:0] EXIT_B = 8'hBB
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open,
   output logic       idx_load
);
   key_state_t st;

   generate
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("cfgp_key_fsm: both key bytes are equal");
      end
      if (EXIT_B == KEY_A) begin : g_bad_exit
         $error("cfgp_key_fsm: exit byte equals first key byte");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= KS_LOCKED;
      end else if (idx_wr) begin
         case (st)
            KS_LOCKED: st <= (wdata == KEY_A) ? KS_HALF : KS_LOCKED;
            KS_HALF:   st <= (wdata == KEY_B) ? KS_OPEN : KS_LOCKED;
            KS_OPEN:   st <= (wdata == EXIT_B) ? KS_LOCKED : KS_OPEN;
            default:   st <= KS_LOCKED;
         endcase
      end
   end

   assign open     = (st == KS_OPEN);
   assign idx_load = idx_wr && open && (wdata != EXIT_B);

   assert_open_needs_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(idx_wr && wdata == KEY_B));
   assert_exit_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (open && idx_wr && wdata == EXIT_B) |=> !open);
   assert_half_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == KS_HALF && idx_wr && wdata != KEY_B) |=> (st == KS_LOCKED));
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
   import cfgp_pkg::*;
#(
   parameter int IRQ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [7:0]       index,
   input  logic [7:0]       wdata,
   output logic             active,
   output logic [15:0]      base,
   output logic [IRQ_W-1:0] irq,
   output logic [7:0]       rd_byte
);
   logic [7:0] irq_rd;

   generate
      if (IRQ_W < 1 || IRQ_W > 8) begin : g_bad_irq
         $error("cfgp_dev_bank: IRQ_W must be 1..8");
      end
      if (IRQ_W == 8) begin : g_irq_full
         assign irq_rd = irq;
      end else begin : g_irq_ext
         assign irq_rd = {{(8-IRQ_W){1'b0}}, irq};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         base   <= '0;
         irq    <= '0;
      end else if (clr) begin
         active <= 1'b0;
         base   <= '0;
         irq    <= '0;
      end else if (we) begin
         case (index)
            IDX_ACT: active     <= wdata[0];
            IDX_BHI: base[15:8] <= wdata;
            IDX_BLO: base[7:0]  <= wdata;
            IDX_IRQ: irq        <= wdata[IRQ_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (index)
         IDX_ACT: rd_byte = {7'd0, active};
         IDX_BHI: rd_byte = base[15:8];
         IDX_BLO: rd_byte = base[7:0];
         IDX_IRQ: rd_byte = irq_rd;
         default: rd_byte = 8'h00;
      endcase
   end

   assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!active && base == 16'h0 && irq == '0));
   assert_hold_unless_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !clr) |=> ($stable(active) && $stable(base) && $stable(irq)));
endmodule

// File: rtl/cfgp_glob_regs.sv
module cfgp_glob_regs
   import cfgp_pkg::*;
#(
   parameter int NUM_DEV = 9,
   localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       index,
   input  logic [7:0]       wdata,
   output logic [LDN_W-1:0] ldn,
   output logic [7:0]       gsel,
   output logic             soft_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ldn  <= '0;
         gsel <= 8'h00;
      end else if (we) begin
         if (index == IDX_LDN && wdata < 8'(NUM_DEV)) ldn <= wdata[LDN_W-1:0];
         if (index == IDX_GSEL) gsel <= wdata;
      end
   end

   assign soft_clr = we && (index == IDX_SRST) && wdata[0];

   assert_ldn_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ldn) < NUM_DEV);
   assert_gsel_kept_on_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> $stable(gsel) && $stable(ldn));
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
   import cfgp_pkg::*;
#(
   parameter int         NUM_DEV = 9,
   parameter int         IRQ_W   = 4,
   parameter logic [7:0] KEY_A   = 8'h51,
   parameter logic [7:0] KEY_B   = 8'h23,
   parameter logic [7:0] EXIT_B  = 8'hBB
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     port_sel,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   output logic                     cfg_open,
   output logic [NUM_DEV-1:0]       dev_active,
   output logic [NUM_DEV*16-1:0]    dev_base,
   output logic [NUM_DEV*IRQ_W-1:0] dev_irq,
   output logic                     gpio_win_en,
   output logic [1:0]               gpio_win_sel
);
   localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

   generate
      if (NUM_DEV < 1 || NUM_DEV > 16) begin : g_bad_ndev
         $error("cfgp_port: NUM_DEV must be 1..16");
      end
   endgenerate

   logic             idx_wr, dat_wr, idx_load, dat_we;
   logic [7:0]       index;
   logic [LDN_W-1:0] ldn;
   logic [7:0]       gsel;
   logic             soft_clr;
   logic [7:0]       bank_rd [NUM_DEV];
   logic [7:0]       sel_bank_rd;

   assign idx_wr = wr_en && !port_sel;
   assign dat_wr = wr_en && port_sel;

   cfgp_key_fsm #(.KEY_A(KEY_A), .KEY_B(KEY_B), .EXIT_B(EXIT_B)) u_key (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(wdata),
      .open(cfg_open), .idx_load(idx_load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        index <= 8'h00;
      else if (idx_load) index <= wdata;
   end

   assign dat_we = dat_wr && cfg_open;

   cfgp_glob_regs #(.NUM_DEV(NUM_DEV)) u_glob (
      .clk(clk), .rst_n(rst_n), .we(dat_we), .index(index), .wdata(wdata),
      .ldn(ldn), .gsel(gsel), .soft_clr(soft_clr)
   );

   assign gpio_win_en  = gsel[7];
   assign gpio_win_sel = gsel[1:0];

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
      logic bank_we;
      assign bank_we = dat_we && (ldn == LDN_W'(d)) && is_bank_idx(index);
      cfgp_dev_bank #(.IRQ_W(IRQ_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .clr(soft_clr), .we(bank_we),
         .index(index), .wdata(wdata),
         .active(dev_active[d]),
         .base(dev_base[d*16 +: 16]),
         .irq(dev_irq[d*IRQ_W +: IRQ_W]),
         .rd_byte(bank_rd[d])
      );
   end

   always_comb begin
      sel_bank_rd = 8'h00;
      for (int d = 0; d < NUM_DEV; d++) begin
         if (ldn == LDN_W'(d)) sel_bank_rd = bank_rd[d];
      end
   end

   always_comb begin
      if (!rd_en)         rdata = 8'h00;
      else if (!cfg_open) rdata = 8'hFF;
      else if (!port_sel) rdata = index;
      else if (is_bank_idx(index)) rdata = sel_bank_rd;
      else begin
         case (index)
            IDX_GSEL: rdata = gsel;
            IDX_LDN:  rdata = 8'(ldn);
            default:  rdata = 8'h00;
         endcase
      end
   end

   assert_closed_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && wr_en) |=> ($stable(dev_active) && $stable(dev_base) &&
                                $stable(dev_irq) && $stable(gpio_win_en) && $stable(index)));
   assert_closed_reads_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && rd_en) |-> rdata == 8'hFF);
   assert_idle_read_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rdata == 8'h00);
endmodule

// File: tb/tb_cfgp_port.sv
module tb_cfgp_port;
   localparam int ND = 9;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic cfg_open;
   logic [ND-1:0] dev_active;
   logic [ND*16-1:0] dev_base;
   logic [ND*IW-1:0] dev_irq;
   logic gpio_win_en;
   logic [1:0] gpio_win_sel;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfgp_port #(.NUM_DEV(ND), .IRQ_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .cfg_open(cfg_open), .dev_active(dev_active),
      .dev_base(dev_base), .dev_irq(dev_irq), .gpio_win_en(gpio_win_en),
      .gpio_win_sel(gpio_win_sel)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] v);
      @(negedge clk);
      port_sel = sel; wdata = v; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      @(negedge clk);
      port_sel = sel; rd_en = 1'b1;
      #1 v = rdata;
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic unlock();
      wr(1'b0, 8'h51); wr(1'b0, 8'h23);
   endtask

   task automatic setreg(input logic [7:0] idx, input logic [7:0] v);
      wr(1'b0, idx); wr(1'b1, v);
   endtask

   task automatic getreg(input logic [7:0] idx, output logic [7:0] v);
      wr(1'b0, idx); rd(1'b1, v);
   endtask

   initial begin
      #1500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R12 reset state
      chk("R12 open", 32'(cfg_open), 0);
      chk("R12 active", 32'(dev_active), 0);
      chk("R12 base", 32'(dev_base[0 +: 16] | dev_base[8*16 +: 16]), 0);
      chk("R12 irq", 32'(dev_irq != '0), 0);
      chk("R12 window", 32'({gpio_win_en, gpio_win_sel}), 0);
      // R13 idle read
      @(negedge clk); chk("R13 idle rdata", 32'(rdata), 0);
      // R4 closed read
      rd(1'b1, v); chk("R4 closed data read", 32'(v), 32'hFF);
      rd(1'b0, v); chk("R4 closed index read", 32'(v), 32'hFF);

      // R1/R2 sweep of every second key byte
      for (int b = 0; b < 256; b++) begin
         wr(1'b0, 8'h51); wr(1'b0, 8'(b));
         chk((b == 8'h23) ? "R1 key opens" : "R2 wrong second byte", 32'(cfg_open),
             32'(b == 8'h23));
         if (cfg_open) wr(1'b0, 8'hBB);
      end
      // R2 doubled first byte then 0x23
      wr(1'b0, 8'h51); wr(1'b0, 8'h51); wr(1'b0, 8'h23);
      chk("R2 51 51 23 stays closed", 32'(cfg_open), 0);
      wr(1'b0, 8'h51); wr(1'b0, 8'h00); wr(1'b0, 8'h23);
      chk("R2 non-adjacent key", 32'(cfg_open), 0);
      // R12 readbacks after unlock
      unlock();
      chk("R1 open", 32'(cfg_open), 1);
      getreg(8'h07, v); chk("R12 ldn zero", 32'(v), 0);
      getreg(8'h03, v); chk("R12 gsel zero", 32'(v), 0);

      // R5-R8 sweep of all devices
      for (int d = 0; d < ND; d++) begin
         setreg(8'h07, 8'(d));
         setreg(8'h30, 8'(8'hFE | (d & 1)));
         setreg(8'h60, 8'(8'h10 + d));
         setreg(8'h61, 8'(8'h11 * d));
         setreg(8'h70, 8'(8'hA0 + d + 3));
      end
      for (int d = 0; d < ND; d++) begin
         chk("R6 active pin", 32'(dev_active[d]), 32'(d & 1));
         chk("R7 base pin", 32'(dev_base[d*16 +: 16]), 32'(((16 + d) << 8) | ((17 * d) & 255)));
         chk("R8 irq pin", 32'(dev_irq[d*IW +: IW]), 32'((d + 3) & 15));
      end
      for (int d = ND - 1; d >= 0; d--) begin
         setreg(8'h07, 8'(d));
         getreg(8'h07, v); chk("R5 ldn readback", 32'(v), 32'(d));
         getreg(8'h30, v); chk("R6 active read", 32'(v), 32'(d & 1));
         getreg(8'h60, v); chk("R7 base hi read", 32'(v), 32'(16 + d));
         getreg(8'h61, v); chk("R7 base lo read", 32'(v), 32'((17 * d) & 255));
         getreg(8'h70, v); chk("R8 irq read", 32'(v), 32'((d + 3) & 15));
      end
      // R5 out-of-range selection ignored (selection is 0 here)
      setreg(8'h07, 8'd4);
      setreg(8'h07, 8'(ND));
      getreg(8'h07, v); chk("R5 ldn out of range", 32'(v), 4);
      setreg(8'h07, 8'hFF);
      getreg(8'h07, v); chk("R5 ldn 0xFF ignored", 32'(v), 4);

      // R11 undefined indices and index readback
      getreg(8'h31, v); chk("R11 undefined bank idx", 32'(v), 0);
      getreg(8'h05, v); chk("R11 undefined global idx", 32'(v), 0);
      rd(1'b0, v); chk("R11 index readback", 32'(v), 32'h05);

      // R10 window byte
      setreg(8'h03, 8'h83);
      chk("R10 win en", 32'(gpio_win_en), 1);
      chk("R10 win sel", 32'(gpio_win_sel), 3);
      getreg(8'h03, v); chk("R10 readback", 32'(v), 32'h83);
      setreg(8'h03, 8'h02);
      chk("R10 win en off", 32'({gpio_win_en, gpio_win_sel}), 2);

      // R3 exit byte closes and is not stored
      wr(1'b0, 8'h61);
      wr(1'b0, 8'hBB);
      chk("R3 closed", 32'(cfg_open), 0);
      // R4 writes while closed ignored
      wr(1'b1, 8'h99);
      wr(1'b0, 8'h30);
      wr(1'b1, 8'h01);
      chk("R4 base pin unchanged", 32'(dev_base[4*16 +: 16]), 32'h1444);
      unlock();
      rd(1'b0, v); chk("R3 index kept", 32'(v), 32'h61);
      rd(1'b1, v); chk("R4 base lo unchanged", 32'(v), 32'h44);

      // R9 soft reset
      setreg(8'h02, 8'h00);
      chk("R9 bit0 clear no reset", 32'(dev_active), 32'h0AA);
      setreg(8'h02, 8'h01);
      chk("R9 active cleared", 32'(dev_active), 0);
      chk("R9 base cleared", 32'(dev_base[1*16 +: 16] | dev_base[8*16 +: 16]), 0);
      chk("R9 irq cleared", 32'(dev_irq != '0), 0);
      getreg(8'h02, v); chk("R9 reads zero", 32'(v), 0);
      getreg(8'h07, v); chk("R9 ldn kept", 32'(v), 4);
      getreg(8'h03, v); chk("R9 gsel kept", 32'(v), 32'h02);
      @(negedge clk); chk("R13 idle after reads", 32'(rdata), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule